// File: doc/BRIEF.md
# SPI Hold Pause Controller

This block sits beside the serial engine of an SPI slave and handles its active-low hold input. When the host pulls hold low in the middle of a transfer, the block raises a pause flag. That flag freezes the engine's shift and bit-count logic without resetting it. A second flag forces the serial output to high impedance. When hold is released under the right conditions, the pause flag drops and the engine carries on from the bit at which it stopped.

The block samples already-synchronised chip select, serial clock and hold levels on the system clock. Whether a hold request takes effect at once depends on the serial clock level when the request arrives. If the serial clock is low, the pause starts in the next system cycle. If the serial clock is high, the pause is armed and starts at the next serial clock falling edge. A release counts only when hold rises while the serial clock is low. Hold has no effect while the slave is deselected, and deselection clears any pause or armed entry.

Top module: `hold_pause_ctrl`

## Requirements
- R1: After reset, with chip select high, `pause_o` is 0 and `so_hiz_o` is 1.
- R2: While selected, if `holdn_i` goes from 1 to 0 while `sck_i` is 0, `pause_o` is 1 one system clock after that sample.
- R3: While selected, if `holdn_i` goes from 1 to 0 while `sck_i` is 1, `pause_o` stays 0. It becomes 1 one system clock after the first sample in which `sck_i` goes from 1 to 0 with `holdn_i` still 0.
- R4: If `holdn_i` returns to 1 before the serial clock falling edge that would start a deferred pause, the entry is cancelled and the later falling edge does not pause.
- R5: While paused, if `holdn_i` goes from 0 to 1 while `sck_i` is 0, `pause_o` is 0 one system clock later.
- R6: While paused, if `holdn_i` goes from 0 to 1 while `sck_i` is 1, the block stays paused. A later serial clock fall does not resume it; only a fresh hold low-then-high with `sck_i` at 0 does.
- R7: `so_hiz_o` is 1 in the same cycle whenever `holdn_i` is 0, `pause_o` is 1, or `csn_i` is 1. Otherwise it is 0.
- R8: A sample with `csn_i` at 1 clears any pause or armed entry, so `pause_o` is 0 one clock later. Hold edges and serial clock edges seen while deselected cause no pause.
- R9: If `holdn_i` is 0 in the first sample with `csn_i` at 0 after deselection, the pause starts one clock later if `sck_i` is 0 in that sample. If `sck_i` is 1, the pause starts at the next serial clock fall, with the same timing as R3.
- R10: While paused, toggling `sck_i` with `holdn_i` held at 0 leaves `pause_o` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csn_i | input | 1 | Synchronised chip select, active low |
| sck_i | input | 1 | Synchronised serial clock level |
| holdn_i | input | 1 | Synchronised hold request, active low |
| pause_o | output | 1 | Freezes the serial engine while 1 |
| so_hiz_o | output | 1 | Forces the serial output to high impedance while 1 |

## Verification
The bench builds the block with its default parameters. These track the three control inputs in one register and set reset values that match an idle, deselected bus with hold released. With those values, every hold event can be reached: entry and exit with the serial clock at either level, entry deferred and then cancelled, selection while hold is already low, and deselection in the middle of a pause or an armed entry. The reset values also make sure that the first selection after reset is seen as a selection edge.

// File: rtl/hsp_pkg.sv
package hsp_pkg;

    localparam int NUM_SIG  = 3;
    localparam int SIG_CSN  = 0;
    localparam int SIG_SCK  = 1;
    localparam int SIG_HOLD = 2;

    typedef enum logic [1:0] {
        HP_RUN    = 2'd0,
        HP_ARMED  = 2'd1,
        HP_PAUSED = 2'd2
    } hp_state_e;

    typedef struct packed {
        hp_state_e state;
    } hp_regs_t;

endpackage

// File: rtl/hsp_edge_track.sv
module hsp_edge_track #(
    parameter int               WIDTH     = 3,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sig_i,
    output logic [WIDTH-1:0] prev_q
);

    logic [WIDTH-1:0] prev_d;

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_bit
            always_comb begin
                prev_d[g] = sig_i[g];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) prev_q[g] <= RESET_VAL[g];
                else        prev_q[g] <= prev_d[g];
            end
        end
    endgenerate

endmodule

// File: rtl/hsp_pause_core.sv
module hsp_pause_core
    import hsp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SIG-1:0] cur_i,
    input  logic [NUM_SIG-1:0] prev_i,
    output logic               paused_o
);

    hp_regs_t regs_d, regs_q;

    logic csn_now, sck_now, hold_now;
    logic sel_start, sck_fell, hold_fell, hold_rose, hold_request;

    always_comb begin
        csn_now      = cur_i[SIG_CSN];
        sck_now      = cur_i[SIG_SCK];
        hold_now     = cur_i[SIG_HOLD];
        sel_start    = prev_i[SIG_CSN] && !csn_now;
        sck_fell     = prev_i[SIG_SCK] && !sck_now;
        hold_fell    = prev_i[SIG_HOLD] && !hold_now;
        hold_rose    = !prev_i[SIG_HOLD] && hold_now;
        hold_request = hold_fell || (sel_start && !hold_now);
    end

    always_comb begin
        regs_d = regs_q;
        if (csn_now) begin
            regs_d.state = HP_RUN;
        end else begin
            unique case (regs_q.state)
                HP_RUN: begin
                    if (hold_request)
                        regs_d.state = sck_now ? HP_ARMED : HP_PAUSED;
                end
                HP_ARMED: begin
                    if (hold_now)
                        regs_d.state = HP_RUN;
                    else if (sck_fell)
                        regs_d.state = HP_PAUSED;
                end
                HP_PAUSED: begin
                    if (hold_rose && !sck_now)
                        regs_d.state = HP_RUN;
                end
                default: regs_d.state = HP_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '{state: HP_RUN};
        else        regs_q <= regs_d;
    end

    assign paused_o = (regs_q.state == HP_PAUSED);

    assert_fall_low_pauses_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!csn_now && hold_fell && !sck_now) |=> paused_o);

    assert_deferred_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == HP_ARMED && !csn_now && !hold_now && sck_fell) |=> paused_o);

    assert_cancel_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == HP_ARMED && hold_now) |=> !paused_o);

    assert_rise_high_stays_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (paused_o && !csn_now && hold_rose && sck_now) |=> paused_o);

    assert_deselect_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        csn_now |=> !paused_o);

    assert_hold_sck_toggle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (paused_o && !csn_now && !hold_now) |=> paused_o);

endmodule

// File: rtl/hold_pause_ctrl.sv
module hold_pause_ctrl
    import hsp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic csn_i,
    input  logic sck_i,
    input  logic holdn_i,
    output logic pause_o,
    output logic so_hiz_o
);

    localparam logic [NUM_SIG-1:0] IDLE_LEVELS =
        (NUM_SIG'(1) << SIG_CSN) | (NUM_SIG'(1) << SIG_HOLD);

    logic [NUM_SIG-1:0] cur_lvl;
    logic [NUM_SIG-1:0] prev_lvl;
    logic               paused;

    always_comb begin
        cur_lvl           = '0;
        cur_lvl[SIG_CSN]  = csn_i;
        cur_lvl[SIG_SCK]  = sck_i;
        cur_lvl[SIG_HOLD] = holdn_i;
    end

    hsp_edge_track #(
        .WIDTH     (NUM_SIG),
        .RESET_VAL (IDLE_LEVELS)
    ) u_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (cur_lvl),
        .prev_q (prev_lvl)
    );

    hsp_pause_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .cur_i    (cur_lvl),
        .prev_i   (prev_lvl),
        .paused_o (paused)
    );

    assign pause_o  = paused;
    assign so_hiz_o = paused || !holdn_i || csn_i;

    assert_resume_cond_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pause_o) && !$past(csn_i)) |-> ($past(holdn_i) && !$past(sck_i)));

    always_comb begin
        if (rst_n && !holdn_i)
            assert_hiz_on_hold_R7: assert (so_hiz_o);
    end

endmodule

// File: tb/sim_hold_pause_ctrl.sv
module sim_hold_pause_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csn = 1'b1;
    logic sck = 1'b0;
    logic holdn = 1'b1;
    logic pause_o, so_hiz_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic  exp_pause;
        logic  exp_hiz;
        string tag;
    } exp_item_t;

    exp_item_t sb_q[$];

    always #5 clk = ~clk;

    hold_pause_ctrl u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .csn_i    (csn),
        .sck_i    (sck),
        .holdn_i  (holdn),
        .pause_o  (pause_o),
        .so_hiz_o (so_hiz_o)
    );

    task automatic step(input logic c, input logic s, input logic h,
                        input logic ep, input logic ez, input string tag);
        exp_item_t it;
        @(negedge clk);
        csn = c; sck = s; holdn = h;
        it.exp_pause = ep; it.exp_hiz = ez; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // monitor: samples 2 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_item_t it;
                it = sb_q.pop_front();
                checks++;
                if (pause_o !== it.exp_pause) begin
                    failures++;
                    $display("FAIL %s pause_o actual=%b expected=%b", it.tag, pause_o, it.exp_pause);
                end
                checks++;
                if (so_hiz_o !== it.exp_hiz) begin
                    failures++;
                    $display("FAIL %s so_hiz_o actual=%b expected=%b", it.tag, so_hiz_o, it.exp_hiz);
                end
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        step(1, 0, 1, 0, 1, "R1");
        // R2 / R7 select and run
        step(0, 0, 1, 0, 0, "R7");
        step(0, 1, 1, 0, 0, "R7");
        step(0, 0, 1, 0, 0, "R7");
        step(0, 0, 0, 1, 1, "R2");
        // R10 serial clock toggles while paused
        step(0, 1, 0, 1, 1, "R10");
        step(0, 0, 0, 1, 1, "R10");
        // R5 resume with sck low
        step(0, 0, 1, 0, 0, "R5");
        // R3 deferred entry
        step(0, 1, 1, 0, 0, "R3");
        step(0, 1, 0, 0, 1, "R3");
        step(0, 1, 0, 0, 1, "R3");
        step(0, 0, 0, 1, 1, "R3");
        // R6 release while sck high does not resume
        step(0, 1, 0, 1, 1, "R6");
        step(0, 1, 1, 1, 1, "R6");
        step(0, 0, 1, 1, 1, "R6");
        step(0, 0, 0, 1, 1, "R6");
        step(0, 0, 1, 0, 0, "R6");
        // R4 armed entry cancelled
        step(0, 1, 1, 0, 0, "R4");
        step(0, 1, 0, 0, 1, "R4");
        step(0, 1, 1, 0, 0, "R4");
        step(0, 0, 1, 0, 0, "R4");
        // R8 deselect clears pause and armed entry
        step(0, 0, 0, 1, 1, "R8");
        step(1, 0, 0, 0, 1, "R8");
        step(1, 0, 1, 0, 1, "R8");
        step(1, 0, 0, 0, 1, "R8");
        step(0, 1, 1, 0, 0, "R8");
        step(0, 1, 0, 0, 1, "R8");
        step(1, 1, 0, 0, 1, "R8");
        step(1, 0, 0, 0, 1, "R8");
        // R9 selection while hold already low
        step(0, 0, 0, 1, 1, "R9");
        step(1, 0, 1, 0, 1, "R9");
        step(1, 1, 0, 0, 1, "R9");
        step(0, 1, 0, 0, 1, "R9");
        step(0, 0, 0, 1, 1, "R9");
        step(0, 0, 1, 0, 0, "R5");
        step(1, 0, 1, 0, 1, "R7");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule